// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Sampling

This block is a serial test access port in the IEEE 1149.1 style. It is meant to sit beside a memory or other functional core. It has a sixteen-state controller stepped by TMS on rising TCK edges, and a three-bit instruction register. It has three data paths: a one-bit bypass cell, a 32-bit identification word and a boundary register whose length is set by a parameter. A board tester drives TMS and TDI and reads TDO to identify the part and to take snapshots of the functional pin values.

Two instructions capture the parallel pin bus into the boundary register. One of them also raises a flag that tells the functional logic to turn its data and clock outputs off while that instruction is in force. TDO is registered on the falling TCK edge and is marked as driven only while a register is being shifted.

Top module: `scan_tap`

## Requirements
- R1: Instruction decode: 001 selects the identification word, 100 selects the boundary register (plain sample), and 010 selects the boundary register with outputs disabled. Every other code (000, 011, 101, 110, 111) selects the one-bit bypass path.
- R2: The active instruction becomes 001 under reset and in Test-Logic-Reset. Capture-IR loads 001 into the instruction shift stage, so the first three bits shifted out of Shift-IR, LSB first, read 001. The active instruction changes only on the rising edge taken in Update-IR.
- R3: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state.
- R4: TDI is sampled on the rising TCK edge. TDO changes only on the falling edge and holds its value across the rising edge.
- R5: `tdo_en` is high only while the controller is in Shift-IR or Shift-DR. It is updated on the falling edge.
- R6: Every scan path takes TDI into its MSB and presents its LSB on TDO. A path of N bits therefore returns its TDI stream delayed by N shifts.
- R7: The bypass path is one bit long and captures 0 in Capture-DR.
- R8: The identification word is {ID_REV[3:0], ID_PART[15:0], ID_MFR[10:0], 1'b1}, with bit 0 shifted out first.
- R9: `func_off` is high exactly while instruction 010 is active. It rises or falls only after Update-IR, or falls on reset or Test-Logic-Reset.
- R10: Under instruction 100 or 010, Capture-DR loads pin bit i into boundary cell i for i < PIN_W. Cells at PIN_W and above load 1. Cell 0 is shifted out first.
- R11: A synchronous active-high `rst` forces Test-Logic-Reset, instruction 001, `tdo_en` low and `func_off` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| pins | input | PIN_W | Parallel functional pin values to sample |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| func_off | output | 1 | Request to disable functional data and clock outputs |

## Verification
The hardest states to reach from the ports are the interval between shifting a new instruction and updating it, and a forced reset begun from deep inside a data shift. The bench stops in Exit1-IR after shifting the output-disable code and checks that `func_off` is still low there. It then checks that the flag rises only after Update-IR. The five-ones case is entered from Shift-DR under a bypass instruction. An identification readback afterwards confirms that the controller and the instruction both returned to their reset values. The half-cycle TDO timing is probed by sampling TDO just after a rising edge and again just after the following falling edge.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PADR, ST_EX2DR,
    ST_UPDR, ST_SELIR, ST_CAPIR, ST_SHIR, ST_EX1IR, ST_PAIR, ST_EX2IR, ST_UPIR
  } tap_state_t;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_t;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;

  function automatic dr_path_t decode_op(logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:            return PATH_ID;
      OP_SAMPZ, OP_SAMPLE:  return PATH_BSR;
      default:              return PATH_BYP;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t nxt;

  always_comb begin
    case (state)
      ST_TLR:   nxt = tms ? ST_TLR   : ST_RTI;
      ST_RTI:   nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELDR: nxt = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: nxt = tms ? ST_UPDR  : ST_PADR;
      ST_PADR:  nxt = tms ? ST_EX2DR : ST_PADR;
      ST_EX2DR: nxt = tms ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELIR: nxt = tms ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: nxt = tms ? ST_UPIR  : ST_PAIR;
      ST_PAIR:  nxt = tms ? ST_EX2IR : ST_PAIR;
      ST_EX2IR: nxt = tms ? ST_UPIR  : ST_SHIR;
      ST_UPIR:  nxt = tms ? ST_SELDR : ST_RTI;
      default:  nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_TLR;
    else     state <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic            ir_lsb,
  output logic [IR_W-1:0] active,
  output logic            func_off
);

  logic [IR_W-1:0] shift_q;

  always_ff @(posedge tck) begin
    if (rst || state == ST_TLR) begin
      shift_q  <= OP_IDCODE;
      active   <= OP_IDCODE;
      func_off <= 1'b0;
    end else begin
      case (state)
        ST_CAPIR: shift_q <= OP_IDCODE;
        ST_SHIR:  shift_q <= {tdi, shift_q[IR_W-1:1]};
        ST_UPIR: begin
          active   <= shift_q;
          func_off <= (shift_q == OP_SAMPZ);
        end
        default: ;
      endcase
    end
  end

  assign ir_lsb = shift_q[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN = 68,
  parameter int          PIN_W   = 67,
  parameter logic [31:0] ID_VAL  = 32'h1
)(
  input  logic             tck,
  input  logic             rst,
  input  tap_state_t       state,
  input  dr_path_t         path,
  input  logic             tdi,
  input  logic [PIN_W-1:0] pins,
  output logic             dr_lsb,
  output logic             byp_bit
);

  localparam int ID_W = 32;

  logic [ID_W-1:0]    id_q;
  logic [BSR_LEN-1:0] bsr_q;
  logic [BSR_LEN-1:0] bsr_cap;

  // capture source per cell: a pin where one exists, a constant 1 otherwise
  generate
    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
      if (i < PIN_W) begin : g_pin
        assign bsr_cap[i] = pins[i];
      end else begin : g_fill
        assign bsr_cap[i] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_bit <= 1'b0;
      id_q    <= ID_VAL;
      bsr_q   <= '0;
    end else if (state == ST_CAPDR) begin
      case (path)
        PATH_ID:  id_q    <= ID_VAL;
        PATH_BSR: bsr_q   <= bsr_cap;
        default:  byp_bit <= 1'b0;
      endcase
    end else if (state == ST_SHDR) begin
      case (path)
        PATH_ID:  id_q    <= {tdi, id_q[ID_W-1:1]};
        PATH_BSR: bsr_q   <= {tdi, bsr_q[BSR_LEN-1:1]};
        default:  byp_bit <= tdi;
      endcase
    end
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_lsb = id_q[0];
      PATH_BSR: dr_lsb = bsr_q[0];
      default:  dr_lsb = byp_bit;
    endcase
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN = 68,
  parameter int          PIN_W   = 67,
  parameter logic [3:0]  ID_REV  = 4'h2,
  parameter logic [15:0] ID_PART = 16'h5A31,
  parameter logic [10:0] ID_MFR  = 11'h2B7
)(
  input  logic             tck,
  input  logic             rst,
  input  logic             tms,
  input  logic             tdi,
  input  logic [PIN_W-1:0] pins,
  output logic             tdo,
  output logic             tdo_en,
  output logic             func_off
);

  localparam logic [31:0] ID_VAL = {ID_REV, ID_PART, ID_MFR, 1'b1};

  tap_state_t      state;
  logic [IR_W-1:0] ir_active;
  logic            ir_lsb;
  logic            dr_lsb;
  logic            byp_bit;
  dr_path_t        path;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck      (tck),
    .rst      (rst),
    .state    (state),
    .tdi      (tdi),
    .ir_lsb   (ir_lsb),
    .active   (ir_active),
    .func_off (func_off)
  );

  assign path = decode_op(ir_active);

  tap_dr #(
    .BSR_LEN (BSR_LEN),
    .PIN_W   (PIN_W),
    .ID_VAL  (ID_VAL)
  ) u_dr (
    .tck     (tck),
    .rst     (rst),
    .state   (state),
    .path    (path),
    .tdi     (tdi),
    .pins    (pins),
    .dr_lsb  (dr_lsb),
    .byp_bit (byp_bit)
  );

  // serial output retimed to the falling edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      case (state)
        ST_SHIR: begin tdo <= ir_lsb; tdo_en <= 1'b1; end
        ST_SHDR: begin tdo <= dr_lsb; tdo_en <= 1'b1; end
        default: begin tdo <= 1'b0;   tdo_en <= 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input tap_state_t      state,
  input logic [IR_W-1:0] active,
  input logic            func_off,
  input logic            tdo_en,
  input logic            byp_bit
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck) begin
    if (rst)      ones_cnt <= '0;
    else if (tms) ones_cnt <= (ones_cnt == 3'd5) ? 3'd5 : ones_cnt + 3'd1;
    else          ones_cnt <= '0;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (rst)
    (ones_cnt == 3'd5) |-> (state == ST_TLR)); // R3

  AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (rst)
    tdo_en |-> (state == ST_SHIR || state == ST_SHDR)); // R5

  AST_IR_ONLY_AT_UPDATE: assert property (@(posedge tck) disable iff (rst)
    (state != ST_UPIR && state != ST_TLR) |=> $stable(active)); // R2

  AST_OFF_RISES_AFTER_UPDATE: assert property (@(posedge tck) disable iff (rst)
    $rose(func_off) |-> ($past(state) == ST_UPIR)); // R9

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAPDR && decode_op(active) == PATH_BYP) |=> !byp_bit); // R7

endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck      (tck),
  .rst      (rst),
  .tms      (tms),
  .state    (state),
  .active   (ir_active),
  .func_off (func_off),
  .tdo_en   (tdo_en),
  .byp_bit  (byp_bit)
);

// File: tb/scan_tap_test.sv
`timescale 1ns/1ps
module scan_tap_test;

  localparam int PIN_W = 67;
  localparam int BSR_LEN = 68;
  localparam logic [31:0] EXP_ID = {4'h2, 16'h5A31, 11'h2B7, 1'b1}; // R8 layout

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [PIN_W-1:0] pins = '0;
  logic tdo, tdo_en, func_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 tck = ~tck;

  scan_tap #(.BSR_LEN(BSR_LEN), .PIN_W(PIN_W), .ID_REV(4'h2),
             .ID_PART(16'h5A31), .ID_MFR(11'h2B7)) uut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .pins(pins),
    .tdo(tdo), .tdo_en(tdo_en), .func_off(func_off));

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic v);
    @(negedge tck); #1;
    tms = v; tdi = 1'b0;
    @(posedge tck); #1;
  endtask

  task automatic shift(int n, logic [127:0] din, output logic [127:0] dout,
                       output logic en_all);
    dout = '0; en_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #1;
      dout[i] = tdo;
      en_all &= tdo_en;
      tdi = din[i];
      tms = (i == n - 1);
      @(posedge tck); #1;
    end
  endtask

  task automatic load_ir(logic [2:0] code, output logic [2:0] cap);
    logic [127:0] o; logic en;
    step(1); step(1); step(0); step(0);
    shift(3, {125'b0, code}, o, en);
    cap = o[2:0];
    step(1); step(0);
  endtask

  task automatic read_dr(int n, logic [127:0] din, output logic [127:0] dout,
                         output logic en);
    step(1); step(0); step(0);
    shift(n, din, dout, en);
    step(1); step(0);
  endtask

  task automatic t_reset;
    chk("R11 tdo_en in reset", tdo_en, 0);
    chk("R11 func_off in reset", func_off, 0);
    step(0);
    chk("R5 tdo_en idle", tdo_en, 0);
  endtask

  task automatic t_idcode;
    logic [127:0] o; logic en;
    read_dr(32, '0, o, en);
    chk("R8 R2 id word after reset", o[31:0], EXP_ID);
    chk("R5 tdo_en during shift", en, 1);
  endtask

  task automatic t_ir_capture;
    logic [2:0] cap;
    load_ir(3'b111, cap);
    chk("R2 capture-IR value", cap, 3'b001);
  endtask

  task automatic t_bypass;
    logic [127:0] o; logic en;
    read_dr(8, 128'hB2, o, en);
    chk("R7 R6 bypass stream", o[7:0], {8'hB2 << 1} & 8'hFE);
  endtask

  task automatic t_edge;
    logic a, b, c;
    step(1); step(0); step(0);          // Shift-DR, bypass active
    @(negedge tck); #1; a = tdo; tdi = 1'b1; tms = 1'b0;
    @(posedge tck); #1; b = tdo;
    chk("R4 tdo first bit", a, 0);
    chk("R4 tdo steady at rising edge", b, 0);
    @(negedge tck); #1; c = tdo; tdi = 1'b0; tms = 1'b1;
    chk("R4 tdo updates on falling edge", c, 1);
    @(posedge tck); #1;
    step(1); step(0);
  endtask

  task automatic t_alias;
    logic [2:0] codes [4] = '{3'b000, 3'b011, 3'b101, 3'b110};
    logic [2:0] cap; logic [127:0] o; logic en;
    for (int k = 0; k < 4; k++) begin
      load_ir(codes[k], cap);
      read_dr(2, 128'h3, o, en);
      chk($sformatf("R1 alias %b is bypass", codes[k]), o[1:0], 2'b10);
      chk("R1 alias keeps outputs on", func_off, 0);
    end
  endtask

  task automatic t_sample;
    logic [2:0] cap; logic [127:0] o; logic en;
    pins = {3'b101, 64'hA5C3_0F1E_7B29_D864};
    load_ir(3'b100, cap);
    chk("R9 sample keeps outputs on", func_off, 0);
    read_dr(BSR_LEN, '0, o, en);
    chk("R10 sample capture", o[BSR_LEN-1:0], {1'b1, pins});
  endtask

  task automatic t_sampz;
    logic [127:0] o; logic en; logic [2:0] cap;
    step(1); step(1); step(0); step(0);
    shift(3, 128'h2, o, en);             // now in Exit1-IR
    chk("R9 flag low before update", func_off, 0);
    step(1); step(0);
    chk("R9 flag high after update", func_off, 1);
    pins = ~{3'b101, 64'hA5C3_0F1E_7B29_D864};
    read_dr(BSR_LEN, '0, o, en);
    chk("R10 sample-z capture", o[BSR_LEN-1:0], {1'b1, pins});
    load_ir(3'b001, cap);
    chk("R9 flag low after idcode", func_off, 0);
  endtask

  task automatic t_five;
    logic [2:0] cap; logic [127:0] o; logic en;
    load_ir(3'b111, cap);
    step(1); step(0); step(0);           // Shift-DR
    for (int k = 0; k < 5; k++) step(1);
    chk("R3 tdo_en off after five ones", tdo_en, 0);
    step(0);
    read_dr(32, '0, o, en);
    chk("R3 id selected after five ones", o[31:0], EXP_ID);
  endtask

  task automatic t_rst;
    logic [2:0] cap; logic [127:0] o; logic en;
    load_ir(3'b010, cap);
    chk("R9 flag set before reset", func_off, 1);
    @(negedge tck); rst = 1'b1;
    repeat (2) @(posedge tck);
    #1;
    chk("R11 flag cleared by reset", func_off, 0);
    @(negedge tck); rst = 1'b0;
    step(0);
    read_dr(32, '0, o, en);
    chk("R11 id selected after reset", o[31:0], EXP_ID);
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #1;
    t_reset_pre: begin
      chk("R11 tdo_en held in reset", tdo_en, 0);
    end
    @(negedge tck); rst = 1'b0;
    t_reset();
    t_idcode();
    t_ir_capture();
    t_bypass();
    t_edge();
    t_alias();
    t_sample();
    t_sampz();
    t_five();
    t_rst();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge tck);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule